// File: doc/BRIEF.md
# Gated Multi-Source Clock Frequency Counter

This block measures the rate of one internal clock chosen from up to 128 candidates. It counts rising edges of the selected clock while a gate window is open. The window is timed in reference ticks, and a parameterised prescaler derives each tick from the bus clock. With a one-microsecond tick, the frequency in Hz is the count times one million, divided by the number of ticks in the window.

Software drives the block through four 32-bit words on a simple write strobe and combinational read port. It writes a control word with the window length, the source index and the enable, continuous, interrupt and start bits. It then polls the busy flag in the same word and reads the count from the result word. The selected clock passes through a two-flop synchroniser and a rising-edge detector in the bus clock domain. The count saturates at all-ones, so a result of all-ones marks an overflowed, invalid measurement. In continuous mode a new window opens as soon as one closes. When the interrupt bit is set, `irq` pulses for one cycle each time a window closes.

Top module: `clk_freq_meter`

## Requirements
- R1: Word addresses are selected by `bus_word`. Word 1 is control and word 3 is the result. Words 0 and 2 always read zero and ignore writes. Control reads back as follows: [15:0] window length minus one, bit 16 enable, bit 17 continuous, bit 18 interrupt enable, bit 19 start (always reads 0), [26:20] source index, bit 31 busy. Bits 30:27 read 0.
- R2: A control write with start=1 and enable=1 while idle opens a window. Busy reads 1 from the next cycle for exactly (length field + 1) × PRESCALE cycles, then drops.
- R3: The result word's low CNT_W bits hold the number of rising edges of the selected source, as seen after a two-flop synchroniser, in the cycles the window was open. The upper bits read 0.
- R4: The 7-bit source field picks bit `src_clks[index]`. A source with no transitions yields a count of 0.
- R5: The count saturates at all-ones of CNT_W bits (0xFFFF by default) and never wraps. A result of all-ones means overflow.
- R6: The result changes only when a window closes. Starts, aborts and register writes leave it unchanged.
- R7: A start written while busy is ignored. This includes the closing cycle of a window. The running window keeps its original length.
- R8: With continuous set, a new window of the current length opens in the cycle after one closes, and busy stays high.
- R9: When the interrupt enable is set, `irq` is high for exactly one cycle after each window closes. When it is clear, `irq` stays low. PRESCALE must be at least 2.
- R10: A control write with enable=0 forces busy low in the next cycle and no later capture or `irq` follows. If that write lands on the closing cycle, that window's capture and `irq` still occur.
- R11: After reset, control and result read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_word | input | 2 | Word index (byte offset bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| src_clks | input | SRC_COUNT | Candidate clocks to measure |
| irq | output | 1 | One-cycle pulse per closed window |

## Verification
Two pairs of functions can land in the same clock edge. One pair is the closing of a window and a control write that aborts it. The other is the closing of a window and a fresh start command. The bench provokes both by timing the second write so it is sampled exactly on the edge where the prescaler and gate counter both expire. It then judges the outcome at the ports. On an abort, the capture and `irq` of the closing window must still appear and busy must fall. On a fresh start, the command must be ignored and busy must fall. A behavioural model tracks every cycle and compares the read data and `irq` on each clock.

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int SRC_COUNT = 128,
  parameter int PRESCALE  = 100,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_word,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [SRC_COUNT-1:0] src_clks,
  output logic                 irq
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [15:0]      dur_q, gate_q;
  logic [6:0]       src_q;
  logic             en_q, cont_q, ie_q, busy_q, irq_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, res_q, cnt_next;
  logic [2:0]       sync_q;
  logic [127:0]     src_pad;
  logic             ctrl_wr, edge_hit, tick, unused_wbits;

  assign src_pad      = 128'(src_clks);
  assign ctrl_wr      = bus_wr && (bus_word == 2'd1);
  assign edge_hit     = sync_q[1] & ~sync_q[2];
  assign tick         = (pre_q == PRE_LAST);
  assign cnt_next     = (edge_hit && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  assign irq          = irq_q;
  assign unused_wbits = ^bus_wdata[31:27];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], src_pad[src_q]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dur_q <= '0; src_q <= '0; en_q <= 1'b0; cont_q <= 1'b0; ie_q <= 1'b0;
      busy_q <= 1'b0; gate_q <= '0; pre_q <= '0; cnt_q <= '0; res_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_next;
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) begin
          if (gate_q == '0) begin
            res_q <= cnt_next;
            irq_q <= ie_q;
            if (cont_q) begin
              gate_q <= dur_q;
              cnt_q  <= '0;
            end else begin
              busy_q <= 1'b0;
            end
          end else begin
            gate_q <= gate_q - 1'b1;
          end
        end
      end
      if (ctrl_wr) begin
        dur_q  <= bus_wdata[15:0];
        en_q   <= bus_wdata[16];
        cont_q <= bus_wdata[17];
        ie_q   <= bus_wdata[18];
        src_q  <= bus_wdata[26:20];
        if (!bus_wdata[16]) begin
          busy_q <= 1'b0;
        end else if (bus_wdata[19] && !busy_q) begin
          busy_q <= 1'b1;
          gate_q <= bus_wdata[15:0];
          pre_q  <= '0;
          cnt_q  <= '0;
        end
      end
    end
  end

  always_comb begin
    case (bus_word)
      2'd1:    bus_rdata = {busy_q, 4'b0, src_q, 1'b0, ie_q, cont_q, en_q, dur_q};
      2'd3:    bus_rdata = 32'(res_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clk_freq_meter_chk.sv
module clk_freq_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_word,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             busy_q,
  input logic             ie_q,
  input logic [15:0]      gate_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] res_q
);
  logic ctrl_wr, abort_wr;
  assign ctrl_wr  = bus_wr && (bus_word == 2'd1);
  assign abort_wr = ctrl_wr && !bus_wdata[16];

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie_q));
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_q) |-> $stable(res_q));
  p_run_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && gate_q != '0 && !abort_wr) |=> busy_q);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && gate_q != '0 && !ctrl_wr && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == {CNT_W{1'b1}});
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> !busy_q);
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == 2'd3) |-> ((bus_rdata >> CNT_W) == 32'd0));
endmodule

bind clk_freq_meter clk_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .busy_q(busy_q),
  .ie_q(ie_q), .gate_q(gate_q), .cnt_q(cnt_q), .res_q(res_q)
);

// File: tb/clk_freq_meter_bench.sv
module clk_freq_meter_bench;
  localparam int P = 4, CW = 8, NS = 128;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_word = 2'd1;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NS-1:0] src_clks = '0;
  logic irq;
  int n_chk = 0, n_fail = 0, cyc = 0, irq_seen = 0, busy_cnt = 0;

  always #5 clk = ~clk;

  clk_freq_meter #(.SRC_COUNT(NS), .PRESCALE(P), .CNT_W(CW)) u_clk_freq_meter (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_clks(src_clks), .irq(irq));

  // Source i toggles every (i%7)+1 cycles; source 5 is held low.
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NS; i++)
      src_clks[i] = (i == 5) ? 1'b0 : 1'(((cyc / ((i % 7) + 1)) % 2));
  end

  // Behavioural reference model
  int m_dur, m_src, m_gate, m_pre, m_cnt, m_res;
  bit m_en, m_cont, m_ie, m_busy, m_irq;
  bit hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dur = 0; m_src = 0; m_gate = 0; m_pre = 0; m_cnt = 0; m_res = 0;
      m_en = 0; m_cont = 0; m_ie = 0; m_busy = 0; m_irq = 0;
      hist = '{0, 0, 0};
    end else begin
      bit e, was_busy;
      int nxt;
      e = hist[1] && !hist[2];
      hist.push_front(src_clks[m_src]);
      void'(hist.pop_back());
      was_busy = m_busy;
      m_irq = 0;
      if (m_busy) begin
        nxt = (e && m_cnt < CMAX) ? m_cnt + 1 : m_cnt;
        m_cnt = nxt;
        if (m_pre == P - 1) begin
          m_pre = 0;
          if (m_gate == 0) begin
            m_res = nxt;
            m_irq = m_ie;
            if (m_cont) begin m_gate = m_dur; m_cnt = 0; end
            else m_busy = 0;
          end else m_gate--;
        end else m_pre++;
      end
      if (bus_wr && bus_word == 2'd1) begin
        m_dur = bus_wdata[15:0]; m_en = bus_wdata[16]; m_cont = bus_wdata[17];
        m_ie = bus_wdata[18]; m_src = bus_wdata[26:20];
        if (!bus_wdata[16]) m_busy = 0;
        else if (bus_wdata[19] && !was_busy) begin
          m_busy = 1; m_gate = bus_wdata[15:0]; m_pre = 0; m_cnt = 0;
        end
      end
    end
  end

  function automatic logic [31:0] m_rd(input logic [1:0] w);
    case (w)
      2'd1:    return {m_busy, 4'b0, 7'(m_src), 1'b0, m_ie, m_cont, m_en, 16'(m_dur)};
      2'd3:    return 32'(m_res);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      check(bus_rdata === m_rd(bus_word),
            (bus_word == 2'd1) ? "R2 ctrl readback" : (bus_word == 2'd3) ? "R3 result readback" : "R1 spare word",
            bus_rdata, m_rd(bus_word));
      check(irq === m_irq, "R9 irq per cycle", irq, m_irq);
      if (irq) irq_seen++;
      if (bus_word == 2'd1 && bus_rdata[31]) busy_cnt++;
    end
  end

  function automatic logic [31:0] ctl(input int dur, input int src, input bit en,
                                      input bit cont, input bit ie, input bit run);
    return {5'b0, 7'(src), run, ie, cont, en, 16'(dur)};
  endfunction

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 2'd1;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] v);
    bus_word = w; #1; v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int k = 0;
    rd(2'd1, v);
    while (v[31] && k < 5000) begin
      @(negedge clk); rd(2'd1, v); k++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(2'd1, v); check(v == 0, "R11 ctrl after reset", v, 0);
    rd(2'd3, v); check(v == 0, "R11 result after reset", v, 0);
    check(irq == 1'b0, "R11 irq after reset", irq, 0);

    // R1 map and readback
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, v); check(v == 0, "R1 word0 reads zero", v, 0);
    rd(2'd2, v); check(v == 0, "R1 word2 reads zero", v, 0);
    rd(2'd1, v); check(v == 0, "R1 ctrl untouched by spare writes", v, 0);
    wr(2'd1, 32'hF800_0000 | ctl(5, 3, 0, 1, 1, 1));
    rd(2'd1, v); check(v == ctl(5, 3, 0, 1, 1, 0), "R1 ctrl layout", v, ctl(5, 3, 0, 1, 1, 0));

    // R2, R3, R9 single window
    irq_seen = 0; busy_cnt = 0;
    wr(2'd1, ctl(2, 1, 1, 0, 1, 1));
    wait_idle();
    check(busy_cnt == 3 * P, "R2 window length", busy_cnt, 3 * P);
    check(irq_seen == 1, "R9 one irq per window", irq_seen, 1);
    rd(2'd3, v); check(v == 3, "R3 edge count period 4", v, 3);

    // R4 silent source and slow source
    irq_seen = 0;
    wr(2'd1, ctl(1, 5, 1, 0, 0, 1)); wait_idle();
    rd(2'd3, v); check(v == 0, "R4 silent source", v, 0);
    check(irq_seen == 0, "R9 no irq when disabled", irq_seen, 0);
    wr(2'd1, ctl(6, 6, 1, 0, 0, 1)); wait_idle();
    rd(2'd3, v); check(v == 2, "R4 source 6 period 14", v, 2);

    // R7 start while busy ignored
    busy_cnt = 0;
    wr(2'd1, ctl(3, 1, 1, 0, 0, 1));
    repeat (3) @(negedge clk);
    wr(2'd1, ctl(0, 1, 1, 0, 0, 1));
    wait_idle();
    check(busy_cnt == 4 * P, "R7 restart ignored", busy_cnt, 4 * P);

    // R10 abort, R6 hold
    rd(2'd3, r0); irq_seen = 0;
    wr(2'd1, ctl(10, 0, 1, 0, 1, 1));
    repeat (5) @(negedge clk);
    wr(2'd1, ctl(10, 0, 0, 0, 1, 0));
    rd(2'd1, v); check(v[31] == 1'b0, "R10 busy dropped", v[31], 0);
    rd(2'd3, v); check(v == r0, "R6 result held on abort", v, r0);
    repeat (60) @(negedge clk);
    check(irq_seen == 0, "R10 no irq after abort", irq_seen, 0);

    // R5 saturation
    wr(2'd1, ctl(150, 0, 1, 0, 0, 1)); wait_idle();
    rd(2'd3, v); check(v == CMAX, "R5 saturated count", v, CMAX);

    // R8 continuous
    irq_seen = 0;
    wr(2'd1, ctl(1, 1, 1, 1, 1, 1));
    repeat (40) @(negedge clk);
    rd(2'd1, v); check(v[31] == 1'b1, "R8 busy stays high", v[31], 1);
    check(irq_seen == 5, "R8 windows closed", irq_seen, 5);
    rd(2'd3, v); check(v == 2, "R8 per-window count", v, 2);
    wr(2'd1, ctl(1, 1, 0, 0, 0, 0));
    repeat (4) @(negedge clk);

    // Collision: abort on the closing edge
    irq_seen = 0;
    wr(2'd1, ctl(0, 1, 1, 0, 1, 1));
    repeat (P - 1) @(negedge clk);
    wr(2'd1, ctl(0, 1, 0, 0, 1, 0));
    @(negedge clk);
    check(irq_seen == 1, "R10 capture irq survives abort", irq_seen, 1);
    rd(2'd3, v); check(v == 1, "R10 capture on closing abort", v, 1);
    rd(2'd1, v); check(v[31] == 1'b0, "R10 idle after closing abort", v[31], 0);

    // Collision: start on the closing edge
    wr(2'd1, ctl(0, 1, 1, 0, 0, 1));
    repeat (P - 1) @(negedge clk);
    wr(2'd1, ctl(0, 1, 1, 0, 0, 1));
    rd(2'd1, v); check(v[31] == 1'b0, "R7 start on closing edge ignored", v[31], 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule